// File: doc/BRIEF.md
# Bus-Master DMA Channel for a SCSI Host Adapter

This block is the memory-facing DMA engine of a SCSI host adapter. Software programs a starting byte count, a starting memory address and a descriptor-list address into shadow registers. It then issues a start command, which copies those values into working counters and opens the SCSI core's DMA path. The core asks for transfers of some number of bytes in a given direction. The channel clips each request to the bytes that remain. It issues one memory request per transfer and then advances its working address and count by the bytes moved.

A six-bit status word collects done, abort, error, blast-complete and power-down flags, and a copy of the core's interrupt line. A single level interrupt combines the core interrupt with an optionally enabled done flag. One bus-control bit picks how software clears status: either a read returns the flags and then clears them, or software writes ones to the flags it wants cleared. A completion strobe from the core ends a transfer early. It zeroes the count and sets done.

Top module: `bmdma_top`

## Requirements
- R1: After reset the command register reads 0, working count reads 0, working address reads 0xFFFFFFFF, working list address reads 0xFFFFFFFD, status reads 0, and irq, dmaEnable and memReqValid are low.
- R2: Register indices are 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start list address, 7 working list address. Indices 1, 2 and 6 read back what was last written. The command register reads back the written byte ANDed with 0xF7: bit 3 and bits 31:8 always read 0.
- R3: Writes to indices 3, 4 and 7 leave those registers unchanged.
- R4: Command bits [1:0] pick the action, which is taken on the write: 0 idle, 1 blast, 2 abort, 3 start. Start copies start count, start address and start list address into working count, working address and working list address. It clears status bits 0, 1, 2, 3 and 5, and sets dmaEnable. Idle clears dmaEnable.
- R5: A request accepted with a nonzero working count raises memReqValid in the next cycle. memAddr equals the working address, memLen equals the smaller of the requested length and the working count, and memWrite equals the request direction. All of these hold steady until memReqReady.
- R6: On the cycle memReqValid and memReqReady are both high, xferAck is high. After that cycle the working count has dropped and the working address has risen by memLen. Status bit 3 (done) is set when the count reaches 0.
- R7: A request whose xferToMem differs from command bit 7 is acknowledged in the same cycle. It makes no memory request and leaves the counters unchanged.
- R8: A direction-matched request made while the working count is 0 is acknowledged in the same cycle with no memory request, and it sets done.
- R9: irq is high exactly when status bit 4 is set, or when command bit 6 and status bit 3 are both set. Status bit 4 follows coreIrq with one cycle of delay.
- R10: With stsClrByWrite high, a status write clears status bits 1 to 3 wherever the written data has ones. Bits 0, 4 and 5 are not affected, and reads do not clear anything.
- R11: With stsClrByWrite low, status writes are ignored. A status read returns the current value and afterwards clears bits 1 to 3.
- R12: A one-cycle coreDone pulse forces the working count to 0 and sets done.
- R13: A blast command sets status bit 5 and moves no data. An abort command raises abortReq for exactly one cycle, in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (needed for clear-on-read) |
| regAddr | input | 3 | Register word index |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| stsClrByWrite | input | 1 | Bus-control bit: 1 selects write-one-to-clear, 0 selects clear-on-read |
| xferReq | input | 1 | Transfer request from the SCSI core, held until xferAck |
| xferLen | input | LEN_W | Requested byte count |
| xferToMem | input | 1 | Request direction, 1 = device to memory |
| xferAck | output | 1 | Request finished or dropped |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request accepted |
| memAddr | output | 32 | Memory byte address |
| memLen | output | LEN_W | Memory request byte count |
| memWrite | output | 1 | 1 = write to memory |
| coreIrq | input | 1 | Interrupt level from the SCSI core |
| coreDone | input | 1 | Command-complete strobe from the SCSI core |
| dmaEnable | output | 1 | DMA path enable toward the core |
| abortReq | output | 1 | One-cycle cancel request to the core |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check several properties on every cycle. A pending memory request keeps its address and length until it is accepted. Each accepted beat lowers the count and raises the address by exactly the moved length, and done follows a count that runs out. Working registers do not move on software writes, a mismatched request never produces a memory request, and a rising core interrupt appears on irq one cycle later. The bench shows the rest in its scenarios. Its sweep of start counts and request lengths exercises the clipping arithmetic. It also covers the two status-clear modes, the start and reset values, command-bit masking, and the timing of blast and abort.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IDX_W  = 3;

  localparam logic [IDX_W-1:0] IDX_CMD  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_STC  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_SPA  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_WBC  = 3'd3;
  localparam logic [IDX_W-1:0] IDX_WAC  = 3'd4;
  localparam logic [IDX_W-1:0] IDX_STAT = 3'd5;
  localparam logic [IDX_W-1:0] IDX_SLA  = 3'd6;
  localparam logic [IDX_W-1:0] IDX_WLA  = 3'd7;

  localparam logic [7:0] CMD_KEEP_MASK = 8'hF7;
  localparam logic [DATA_W-1:0] WAC_RESET = 32'hFFFF_FFFF;
  localparam logic [DATA_W-1:0] WLA_RESET = 32'hFFFF_FFFD;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BLAST = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } chanOp_e;

  typedef struct packed {
    logic              startLoad;
    logic              stopDma;
    logic              blastHit;
    logic              advance;
    logic              emptyHit;
    logic [DATA_W-1:0] moveLen;
  } strobe_t;
endpackage

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
  import bmdma_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWr,
  input  logic [1:0]        cmdOp,
  input  logic              xferReq,
  input  logic [LEN_W-1:0]  xferLen,
  input  logic              xferToMem,
  input  logic              memReqReady,
  input  logic              cmdDir,
  input  logic [DATA_W-1:0] workCount,
  input  logic [DATA_W-1:0] workAddr,
  output strobe_t           strb,
  output logic              xferAck,
  output logic              memReqValid,
  output logic [DATA_W-1:0] memAddr,
  output logic [LEN_W-1:0]  memLen,
  output logic              memWrite,
  output logic              abortReq
);
  logic              busy;
  logic [LEN_W-1:0]  lenQ;
  logic [DATA_W-1:0] addrQ;
  logic              dirQ;
  logic              dirOk;
  logic              countZero;
  logic              accept;
  logic [DATA_W-1:0] reqLenExt;
  logic [LEN_W-1:0]  clipLen;

  always_comb begin
    dirOk     = (xferToMem == cmdDir);
    countZero = (workCount == '0);
    reqLenExt = DATA_W'(xferLen);
    clipLen   = (reqLenExt < workCount) ? xferLen : workCount[LEN_W-1:0];
    accept    = !busy && xferReq && dirOk && !countZero;

    strb           = '0;
    strb.startLoad = cmdWr && (chanOp_e'(cmdOp) == OP_START);
    strb.stopDma   = cmdWr && (chanOp_e'(cmdOp) == OP_IDLE);
    strb.blastHit  = cmdWr && (chanOp_e'(cmdOp) == OP_BLAST);
    strb.emptyHit  = !busy && xferReq && dirOk && countZero;
    strb.advance   = busy && memReqReady;
    strb.moveLen   = DATA_W'(lenQ);

    xferAck = (!busy && xferReq && (!dirOk || countZero)) || (busy && memReqReady);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      lenQ     <= '0;
      addrQ    <= '0;
      dirQ     <= 1'b0;
      abortReq <= 1'b0;
    end else begin
      abortReq <= cmdWr && (chanOp_e'(cmdOp) == OP_ABORT);
      if (accept) begin
        busy  <= 1'b1;
        lenQ  <= clipLen;
        addrQ <= workAddr;
        dirQ  <= xferToMem;
      end else if (busy && memReqReady) begin
        busy <= 1'b0;
      end
    end
  end

  assign memReqValid = busy;
  assign memAddr     = addrQ;
  assign memLen      = lenQ;
  assign memWrite    = dirQ;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memAddr) && $stable(memLen))); // R5

  AST_DROP_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    (!memReqValid && xferReq && (xferToMem != cmdDir)) |=> !memReqValid); // R7

  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> !abortReq || $past(cmdWr && cmdOp == 2'd2)); // R13
endmodule

// File: rtl/bmdma_dpath.sv
module bmdma_dpath
  import bmdma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [IDX_W-1:0]  regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              stsClrByWrite,
  input  logic              coreIrq,
  input  logic              coreDone,
  input  strobe_t           strb,
  output logic [DATA_W-1:0] regRdData,
  output logic              cmdDir,
  output logic [DATA_W-1:0] workCount,
  output logic [DATA_W-1:0] workAddr,
  output logic              dmaEnable,
  output logic              irq
);
  logic [7:0]        cmdQ;
  logic [DATA_W-1:0] stcQ, spaQ, slaQ, wbcQ, wacQ, wlaQ;
  logic [5:0]        statQ, statNext;
  logic [DATA_W-1:0] nextCount;
  logic              wrStat, rdStat;

  always_comb begin
    nextCount = (strb.moveLen >= wbcQ) ? '0 : (wbcQ - strb.moveLen);
    wrStat    = regWrEn && (regAddr == IDX_STAT);
    rdStat    = regRdEn && (regAddr == IDX_STAT);

    statNext = statQ;
    if (rdStat && !stsClrByWrite) statNext[3:1] = 3'b000;
    if (wrStat && stsClrByWrite)  statNext[3:1] = statQ[3:1] & ~regWrData[3:1];
    if (strb.startLoad) begin
      statNext[3:0] = 4'b0000;
      statNext[5]   = 1'b0;
    end
    if ((strb.advance && nextCount == '0) || strb.emptyHit || coreDone) statNext[3] = 1'b1;
    if (strb.blastHit) statNext[5] = 1'b1;
    statNext[4] = coreIrq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ      <= '0;
      stcQ      <= '0;
      spaQ      <= '0;
      slaQ      <= '0;
      wbcQ      <= '0;
      wacQ      <= WAC_RESET;
      wlaQ      <= WLA_RESET;
      statQ     <= '0;
      dmaEnable <= 1'b0;
    end else begin
      statQ <= statNext;
      if (regWrEn) begin
        case (regAddr)
          IDX_CMD: cmdQ <= regWrData[7:0] & CMD_KEEP_MASK;
          IDX_STC: stcQ <= regWrData;
          IDX_SPA: spaQ <= regWrData;
          IDX_SLA: slaQ <= regWrData;
          default: ;
        endcase
      end
      if (strb.startLoad) begin
        wbcQ      <= stcQ;
        wacQ      <= spaQ;
        wlaQ      <= slaQ;
        dmaEnable <= 1'b1;
      end else begin
        if (strb.stopDma) dmaEnable <= 1'b0;
        if (coreDone) begin
          wbcQ <= '0;
        end else if (strb.advance) begin
          wbcQ <= nextCount;
        end
        if (strb.advance) wacQ <= wacQ + strb.moveLen;
      end
    end
  end

  always_comb begin
    case (regAddr)
      IDX_CMD:  regRdData = DATA_W'(cmdQ);
      IDX_STC:  regRdData = stcQ;
      IDX_SPA:  regRdData = spaQ;
      IDX_WBC:  regRdData = wbcQ;
      IDX_WAC:  regRdData = wacQ;
      IDX_STAT: regRdData = DATA_W'(statQ);
      IDX_SLA:  regRdData = slaQ;
      default:  regRdData = wlaQ;
    endcase
  end

  assign cmdDir    = cmdQ[7];
  assign workCount = wbcQ;
  assign workAddr  = wacQ;
  assign irq       = statQ[4] | (cmdQ[6] & statQ[3]);

  AST_ADV_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.startLoad) |=>
      (wbcQ <= $past(wbcQ)) && (wacQ == $past(wacQ) + $past(strb.moveLen))); // R6

  AST_DONE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.startLoad && strb.moveLen == wbcQ) |=> statQ[3]); // R6

  AST_WORK_RO: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regAddr == IDX_WBC || regAddr == IDX_WAC || regAddr == IDX_WLA)
     && !strb.startLoad && !strb.advance && !coreDone)
      |=> ($stable(wbcQ) && $stable(wacQ) && $stable(wlaQ))); // R3

  AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(coreIrq) |=> irq); // R9

  AST_CORE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (coreDone && !strb.startLoad) |=> (wbcQ == '0 && statQ[3])); // R12
endmodule

// File: rtl/bmdma_top.sv
module bmdma_top
  import bmdma_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              stsClrByWrite,
  input  logic              xferReq,
  input  logic [LEN_W-1:0]  xferLen,
  input  logic              xferToMem,
  output logic              xferAck,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [31:0]       memAddr,
  output logic [LEN_W-1:0]  memLen,
  output logic              memWrite,
  input  logic              coreIrq,
  input  logic              coreDone,
  output logic              dmaEnable,
  output logic              abortReq,
  output logic              irq
);
  strobe_t           strb;
  logic              cmdDir;
  logic [DATA_W-1:0] workCount;
  logic [DATA_W-1:0] workAddr;
  logic              cmdWr;

  assign cmdWr = regWrEn && (regAddr == IDX_CMD);

  bmdma_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .cmdWr       (cmdWr),
    .cmdOp       (regWrData[1:0]),
    .xferReq     (xferReq),
    .xferLen     (xferLen),
    .xferToMem   (xferToMem),
    .memReqReady (memReqReady),
    .cmdDir      (cmdDir),
    .workCount   (workCount),
    .workAddr    (workAddr),
    .strb        (strb),
    .xferAck     (xferAck),
    .memReqValid (memReqValid),
    .memAddr     (memAddr),
    .memLen      (memLen),
    .memWrite    (memWrite),
    .abortReq    (abortReq)
  );

  bmdma_dpath dpath_i (
    .clk           (clk),
    .rstN          (rstN),
    .regWrEn       (regWrEn),
    .regRdEn       (regRdEn),
    .regAddr       (regAddr),
    .regWrData     (regWrData),
    .stsClrByWrite (stsClrByWrite),
    .coreIrq       (coreIrq),
    .coreDone      (coreDone),
    .strb          (strb),
    .regRdData     (regRdData),
    .cmdDir        (cmdDir),
    .workCount     (workCount),
    .workAddr      (workAddr),
    .dmaEnable     (dmaEnable),
    .irq           (irq)
  );
endmodule

// File: tb/bmdma_top_tb_top.sv
`timescale 1ns/1ps
module bmdma_top_tb_top;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rstN;
  logic regWrEn, regRdEn;
  logic [2:0] regAddr;
  logic [31:0] regWrData, regRdData;
  logic stsClrByWrite;
  logic xferReq, xferToMem, xferAck;
  logic [LEN_W-1:0] xferLen, memLen;
  logic memReqValid, memReqReady, memWrite;
  logic [31:0] memAddr;
  logic coreIrq, coreDone, dmaEnable, abortReq, irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bmdma_top #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .stsClrByWrite(stsClrByWrite), .xferReq(xferReq), .xferLen(xferLen),
    .xferToMem(xferToMem), .xferAck(xferAck), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memAddr(memAddr), .memLen(memLen),
    .memWrite(memWrite), .coreIrq(coreIrq), .coreDone(coreDone),
    .dmaEnable(dmaEnable), .abortReq(abortReq), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic doXfer(input logic [LEN_W-1:0] len, input bit toMem, input int waitCyc,
                        input logic [31:0] expA, input logic [LEN_W-1:0] expL, input bit expMem);
    @(negedge clk);
    xferReq = 1'b1; xferLen = len; xferToMem = toMem;
    #1;
    if (!expMem) begin
      chk("R7/R8 immediate ack", {31'd0, xferAck}, 32'd1);
      chk("R7/R8 no mem request", {31'd0, memReqValid}, 32'd0);
      @(negedge clk);
      xferReq = 1'b0;
      #1 chk("R7/R8 still no mem request", {31'd0, memReqValid}, 32'd0);
    end else begin
      chk("R5 no ack at accept", {31'd0, xferAck}, 32'd0);
      @(negedge clk); #1;
      chk("R5 memReqValid", {31'd0, memReqValid}, 32'd1);
      chk("R5 memAddr", memAddr, expA);
      chk("R5 memLen", 32'(memLen), 32'(expL));
      chk("R5 memWrite", {31'd0, memWrite}, {31'd0, toMem});
      for (int i = 0; i < waitCyc; i++) begin
        @(negedge clk); #1;
        chk("R5 held valid", {31'd0, memReqValid}, 32'd1);
        chk("R5 held len", 32'(memLen), 32'(expL));
      end
      memReqReady = 1'b1;
      #1 chk("R6 ack on handshake", {31'd0, xferAck}, 32'd1);
      @(negedge clk);
      memReqReady = 1'b0; xferReq = 1'b0;
      #1 chk("R6 request dropped after handshake", {31'd0, memReqValid}, 32'd0);
    end
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] expCnt, expAdr, clip, base;
    bit first, dir;
    rstN = 1'b0; regWrEn = 0; regRdEn = 0; regAddr = 0; regWrData = 0;
    stsClrByWrite = 1'b1; xferReq = 0; xferLen = 0; xferToMem = 0;
    memReqReady = 0; coreIrq = 0; coreDone = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset values
    #1;
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 dmaEnable", {31'd0, dmaEnable}, 32'd0);
    chk("R1 memReqValid", {31'd0, memReqValid}, 32'd0);
    rdReg(3'd0, v); chk("R1 command", v, 32'd0);
    rdReg(3'd3, v); chk("R1 working count", v, 32'd0);
    rdReg(3'd4, v); chk("R1 working address", v, 32'hFFFF_FFFF);
    rdReg(3'd7, v); chk("R1 working list", v, 32'hFFFF_FFFD);
    rdReg(3'd5, v); chk("R1 status", v, 32'd0);

    // R2 shadow readback and command masking
    wrReg(3'd1, 32'h1234_5678); rdReg(3'd1, v); chk("R2 start count", v, 32'h1234_5678);
    wrReg(3'd2, 32'hCAFE_0000); rdReg(3'd2, v); chk("R2 start address", v, 32'hCAFE_0000);
    wrReg(3'd6, 32'h0BAD_F00D); rdReg(3'd6, v); chk("R2 start list", v, 32'h0BAD_F00D);
    wrReg(3'd0, 32'hFFFF_FFFF); rdReg(3'd0, v); chk("R2 command mask", v, 32'h0000_00F7);

    // R4 start copies shadows
    rdReg(3'd3, v); chk("R4 count copied", v, 32'h1234_5678);
    rdReg(3'd4, v); chk("R4 address copied", v, 32'hCAFE_0000);
    rdReg(3'd7, v); chk("R4 list copied", v, 32'h0BAD_F00D);
    chk("R4 dmaEnable set", {31'd0, dmaEnable}, 32'd1);

    // R3 working registers read-only
    wrReg(3'd3, 32'hDEAD_BEEF); wrReg(3'd4, 32'hDEAD_BEEF); wrReg(3'd7, 32'hDEAD_BEEF);
    rdReg(3'd3, v); chk("R3 count kept", v, 32'h1234_5678);
    rdReg(3'd4, v); chk("R3 address kept", v, 32'hCAFE_0000);
    rdReg(3'd7, v); chk("R3 list kept", v, 32'h0BAD_F00D);

    // R4 idle clears enable
    wrReg(3'd0, 32'h0000_0000);
    #1 chk("R4 idle clears dmaEnable", {31'd0, dmaEnable}, 32'd0);

    // R13 abort pulse
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'd0; regWrData = 32'h2;
    #1 chk("R13 abort not yet", {31'd0, abortReq}, 32'd0);
    @(negedge clk);
    regWrEn = 1'b0;
    #1 chk("R13 abort pulse high", {31'd0, abortReq}, 32'd1);
    @(negedge clk);
    #1 chk("R13 abort pulse ends", {31'd0, abortReq}, 32'd0);

    // R13 blast sets bit 5; R10 bit 5 not cleared by write
    wrReg(3'd0, 32'h1);
    rdReg(3'd5, v); chk("R13 blast complete", v, 32'h20);
    wrReg(3'd5, 32'h20);
    rdReg(3'd5, v); chk("R10 bit5 not write-clearable", v, 32'h20);

    // R6/R5/R8 sweep of start counts and request lengths
    for (int cnt = 0; cnt <= 5; cnt++) begin
      for (int len = 1; len <= 4; len++) begin
        dir = (len % 2) == 1;
        base = 32'h1000 + 32'(cnt * 64 + len * 8);
        wrReg(3'd1, 32'(cnt));
        wrReg(3'd2, base);
        wrReg(3'd0, dir ? 32'h83 : 32'h03);
        expCnt = 32'(cnt); expAdr = base;
        rdReg(3'd5, v); chk("R4 start clears status", v, 32'h0);
        first = 1;
        while (first || expCnt != 0) begin
          first = 0;
          clip = (32'(len) < expCnt) ? 32'(len) : expCnt;
          doXfer(LEN_W'(len), dir, (len + cnt) % 3, expAdr, LEN_W'(clip), expCnt != 0);
          expCnt = expCnt - clip; expAdr = expAdr + clip;
          rdReg(3'd3, v); chk("R6 working count", v, expCnt);
          rdReg(3'd4, v); chk("R6 working address", v, expAdr);
          rdReg(3'd5, v);
          chk("R6/R8 done flag", {31'd0, v[3]}, {31'd0, expCnt == 0});
        end
      end
    end

    // R7 direction mismatch dropped
    wrReg(3'd1, 32'd8); wrReg(3'd2, 32'h4000); wrReg(3'd0, 32'h83);
    doXfer(16'd4, 1'b0, 0, 32'h0, 16'd0, 1'b0);
    rdReg(3'd3, v); chk("R7 count unchanged", v, 32'd8);
    rdReg(3'd4, v); chk("R7 address unchanged", v, 32'h4000);

    // R12 core completion
    @(negedge clk); coreDone = 1'b1;
    @(negedge clk); coreDone = 1'b0;
    rdReg(3'd3, v); chk("R12 count forced zero", v, 32'd0);
    rdReg(3'd5, v); chk("R12 done set", v, 32'h08);

    // R10 write-one-to-clear
    wrReg(3'd5, 32'h30);
    rdReg(3'd5, v); chk("R10 unrelated ones ignored", v, 32'h08);
    wrReg(3'd5, 32'h08);
    rdReg(3'd5, v); chk("R10 done cleared by write", v, 32'h00);

    // R11 clear-on-read mode
    wrReg(3'd1, 32'd0); wrReg(3'd0, 32'h03);
    doXfer(16'd2, 1'b0, 0, 32'h0, 16'd0, 1'b0);
    stsClrByWrite = 1'b0;
    wrReg(3'd5, 32'hFF);
    rdReg(3'd5, v); chk("R11 write ignored, read returns done", v, 32'h08);
    rdReg(3'd5, v); chk("R11 read cleared done", v, 32'h00);
    stsClrByWrite = 1'b1;

    // R9 interrupt composition
    wrReg(3'd1, 32'd0); wrReg(3'd0, 32'h43);
    #1 chk("R9 irq low after start", {31'd0, irq}, 32'd0);
    doXfer(16'd1, 1'b0, 0, 32'h0, 16'd0, 1'b0);
    #1 chk("R9 irq from enabled done", {31'd0, irq}, 32'd1);
    wrReg(3'd0, 32'h03);
    #1 chk("R9 irq low with enable off", {31'd0, irq}, 32'd0);
    doXfer(16'd1, 1'b0, 0, 32'h0, 16'd0, 1'b0);
    #1 chk("R9 done without enable no irq", {31'd0, irq}, 32'd0);
    @(negedge clk); coreIrq = 1'b1;
    #1 chk("R9 core irq delayed", {31'd0, irq}, 32'd0);
    @(negedge clk);
    #1 chk("R9 core irq on irq", {31'd0, irq}, 32'd1);
    rdReg(3'd5, v); chk("R9 status bit4", {31'd0, v[4]}, 32'd1);
    @(negedge clk); coreIrq = 1'b0;
    @(negedge clk);
    #1 chk("R9 core irq released", {31'd0, irq}, 32'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule